// File: doc/BRIEF.md
# USB Type-C Configuration Channel Attach Controller

This block runs the connection logic for a single USB Type-C port. It reads already-digitised comparator classifications for both CC lines and a VBUS-present flag. From these it chooses which termination to present, works out whether a partner is attached, and decides the port's role, the plug orientation and the current level the partner advertises. All timing is counted in ticks of an external one-millisecond strobe, `ms_tick`. The controller runs in the system clock domain.

The port can be a fixed source, a fixed sink, or a dual-role port. A dual-role port swaps between pull-up and pull-down terminations over a fixed 75 ms period. A 2-bit setting picks the share of that period spent as source. Any CC pattern must hold steady for a selectable debounce time before an attach or a source detach is accepted. A sink attach also needs VBUS to have been present for 2 ms.

The outputs are active-low flags for source attach, sink current level and audio accessory, plus an orientation flag, a per-pin VCONN enable and the termination select. A one-cycle pulse marks every change in attach kind, orientation or current level, so that a wrapper can raise an interrupt from it.

Top module: `cc_port_ctrl`

## Requirements
- R1: While `en_n` is high, the controller sits in a disabled state. One cycle after `en_n` is seen high, `cc_pull` is 2'b00, `vconn_en` is 0 and `orient` is 0. In the same cycle `src_att_n`, `cur_med_n`, `cur_high_n` and `audio_n` are all 1. No `chg_pulse` is raised while disabled.
- R2: `cc_pull` encodes the termination: 2'b01 is pull-down and 2'b10 is pull-up. `mode_sel` 2'b00 gives a fixed sink (pull-down), 2'b01 a fixed source (pull-up), and 2'b10 or 2'b11 a dual-role port. Under pull-up, a pin's class is 00 open, 01 sink pulldown (Rd) or 10 cable/accessory pulldown (Ra). Under pull-down, it is 00 open, 01 default, 10 medium or 11 high current.
- R3: An unattached dual-role port repeats a 75 ms cycle that starts with pull-up. Pull-up is held for 22, 30, 37 or 45 ms when `duty_sel` is 00, 01, 10 or 11. The toggling freezes while an attach is pending or in place, and it resumes after a detach.
- R4: A candidate CC pattern must hold for 168, 134, 118 or 100 ms ticks (`db_sel` 00, 01, 10, 11) before an attach is taken. If the pattern changes to another candidate, the count restarts. If it drops to no candidate, the port returns to unattached.
- R5: A sink attach also needs `vbus_present` high for 2 consecutive ms ticks. A sink detaches in the cycle after `vbus_present` falls.
- R6: While attached as source or sink, `orient` is 1 when CC2 carries the partner and 0 when CC1 does.
- R7: `src_att_n` is low only while attached as source, whether from fixed source or dual-role mode.
- R8: Attached as sink, `cur_med_n` is low for medium or high current, and `cur_high_n` is low only for high. Both follow the active pin live.
- R9: Attached as source with Ra on the pin that does not carry Rd, that pin's bit of `vconn_en` (bit 0 is CC1, bit 1 is CC2) is 1. Otherwise `vconn_en` is 0.
- R10: Ra on both pins under pull-up, held for the debounce time, makes `audio_n` low; `src_att_n` stays high.
- R11: A source or audio attach ends once the Rd (or double Ra) pattern has been absent for the debounce time. Shorter absences are ignored.
- R12: `chg_pulse` is high for one cycle in the cycle where attach kind, orientation or current level changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_n | input | 1 | Active-low enable |
| mode_sel | input | 2 | Port role select |
| db_sel | input | 2 | CC debounce time select |
| duty_sel | input | 2 | Dual-role source share select |
| ms_tick | input | 1 | One-cycle strobe each millisecond |
| cc1_cls | input | 2 | Comparator class of CC1 |
| cc2_cls | input | 2 | Comparator class of CC2 |
| vbus_present | input | 1 | VBUS above threshold |
| orient | output | 1 | Plug orientation |
| src_att_n | output | 1 | Low while attached as source |
| cur_med_n | output | 1 | Low for medium or high sink current |
| cur_high_n | output | 1 | Low for high sink current |
| audio_n | output | 1 | Low while an audio accessory is attached |
| cc_pull | output | 2 | Termination select |
| vconn_en | output | 2 | Per-pin VCONN enable |
| chg_pulse | output | 1 | One-cycle status change strobe |

## Verification
Every output is decoded without a register from the state register. An attach therefore shows one cycle after the tick that completes the debounce, and a VBUS-loss detach shows one cycle after `vbus_present` falls. The bench emits a tick every fourth clock. It checks debounce results a few milliseconds before and after the nominal instant, so that the one-cycle decode and tick phase cannot shift a result across a check. Dual-role duty is measured in clock cycles from one pull-up rising edge to the next, with one tick of tolerance. Disable and VBUS-loss results are sampled two cycles after the stimulus.

// File: rtl/cc_pkg.sv
// Shared types and encodings for the Type-C CC attach controller.
// Assumes the comparator classes are already synchronised to clk.
package cc_pkg;

    typedef enum logic [1:0] {
        PULL_NONE = 2'b00,
        PULL_DOWN = 2'b01,
        PULL_UP   = 2'b10
    } pull_e;

    typedef enum logic [2:0] {
        ST_DIS,
        ST_UNATT,
        ST_WAIT_SRC,
        ST_WAIT_SNK,
        ST_ATT_SRC,
        ST_ATT_SNK,
        ST_ATT_AUD
    } state_e;

    // Class codes seen while presenting pull-up
    localparam logic [1:0] CLS_OPEN = 2'b00;
    localparam logic [1:0] CLS_RD   = 2'b01;
    localparam logic [1:0] CLS_RA   = 2'b10;
    // Class codes seen while presenting pull-down
    localparam logic [1:0] CLS_MED  = 2'b10;
    localparam logic [1:0] CLS_HIGH = 2'b11;

    localparam logic [1:0] MODE_SNK = 2'b00;
    localparam logic [1:0] MODE_SRC = 2'b01;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/cc_ms_timer.sv
// Millisecond timer: counts ms ticks from a clear and saturates at its limit.
// Assumes tick is a single-cycle strobe; done is high once limit ticks are seen.
module cc_ms_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         tick,
    input  logic [W-1:0] limit,
    output logic         done
);
    logic [W-1:0] cnt_q;

    assign done = (cnt_q >= limit);

    // Count ticks, restart on clear, hold once the limit is reached
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt_q <= '0;
        else if (clr)         cnt_q <= '0;
        else if (tick && !done) cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/cc_drp_toggle.sv
// Dual-role period generator: marks the source-advertising share of each period.
// Assumes run is only high while the port is unattached in dual-role mode.
module cc_drp_toggle #(
    parameter int PERIOD_MS = 75,
    parameter int DUTY_PCT0 = 30,
    parameter int DUTY_PCT1 = 40,
    parameter int DUTY_PCT2 = 50,
    parameter int DUTY_PCT3 = 60
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       run,
    input  logic       tick,
    input  logic [1:0] duty_sel,
    output logic       src_phase
);
    localparam int W        = $clog2(PERIOD_MS + 1);
    localparam int SRC_LIM0 = PERIOD_MS * DUTY_PCT0 / 100;
    localparam int SRC_LIM1 = PERIOD_MS * DUTY_PCT1 / 100;
    localparam int SRC_LIM2 = PERIOD_MS * DUTY_PCT2 / 100;
    localparam int SRC_LIM3 = PERIOD_MS * DUTY_PCT3 / 100;

    logic [W-1:0] ph_q;
    logic [W-1:0] src_lim;

    // Select the source share for the programmed duty
    always_comb begin
        case (duty_sel)
            2'b00:   src_lim = W'(SRC_LIM0);
            2'b01:   src_lim = W'(SRC_LIM1);
            2'b10:   src_lim = W'(SRC_LIM2);
            default: src_lim = W'(SRC_LIM3);
        endcase
    end

    assign src_phase = (ph_q < src_lim);

    // Advance the phase counter each ms while toggling, wrapping at the period
    always_ff @(posedge clk) begin
        if (!rst_n || clr)  ph_q <= '0;
        else if (run && tick)
            ph_q <= (ph_q == W'(PERIOD_MS - 1)) ? '0 : ph_q + 1'b1;
    end
endmodule

// File: rtl/cc_status_out.sv
// Output decoder: turns attach state into the active-low flags and change pulse.
// Assumes state, orientation and captured pattern are registered upstream.
module cc_status_out
    import cc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  state_e     st,
    input  logic       orient_q,
    input  logic [3:0] cc_q,
    input  logic [3:0] cc_now,
    output logic       orient,
    output logic       src_att_n,
    output logic       cur_med_n,
    output logic       cur_high_n,
    output logic       audio_n,
    output logic [1:0] vconn_en,
    output logic       chg_pulse
);
    logic       is_src, is_snk, is_aud;
    logic [1:0] act_cls;
    logic [1:0] cur;
    logic [1:0] kind;
    logic [4:0] status, status_q;

    assign is_src = (st == ST_ATT_SRC);
    assign is_snk = (st == ST_ATT_SNK);
    assign is_aud = (st == ST_ATT_AUD);

    // Decode the current level from the live class of the active pin
    always_comb begin
        act_cls = orient_q ? cc_now[3:2] : cc_now[1:0];
        if (!is_snk)                cur = 2'd0;
        else if (act_cls == CLS_HIGH) cur = 2'd2;
        else if (act_cls == CLS_MED)  cur = 2'd1;
        else                          cur = 2'd0;
    end

    assign orient     = (is_src || is_snk) ? orient_q : 1'b0;
    assign src_att_n  = !is_src;
    assign cur_med_n  = !(cur != 2'd0);
    assign cur_high_n = !(cur == 2'd2);
    assign audio_n    = !is_aud;
    assign vconn_en[0] = is_src &&  orient_q && (cc_q[1:0] == CLS_RA);
    assign vconn_en[1] = is_src && !orient_q && (cc_q[3:2] == CLS_RA);

    // Build the reported status vector
    always_comb begin
        kind   = is_src ? 2'd1 : is_snk ? 2'd2 : is_aud ? 2'd3 : 2'd0;
        status = {kind, orient, cur};
    end

    // Remember last cycle's status for change detection
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= status;
    end

    assign chg_pulse = (st != ST_DIS) && (status != status_q);
endmodule

// File: rtl/cc_port_ctrl.sv
// Type-C CC attach controller top: role select, debounce, attach/detach FSM.
// Assumes all inputs are synchronous to clk and ms_tick pulses once per ms.
module cc_port_ctrl
    import cc_pkg::*;
#(
    parameter int DB_MS0    = 168,
    parameter int DB_MS1    = 134,
    parameter int DB_MS2    = 118,
    parameter int DB_MS3    = 100,
    parameter int VBUS_MS   = 2,
    parameter int PERIOD_MS = 75
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_n,
    input  logic [1:0] mode_sel,
    input  logic [1:0] db_sel,
    input  logic [1:0] duty_sel,
    input  logic       ms_tick,
    input  logic [1:0] cc1_cls,
    input  logic [1:0] cc2_cls,
    input  logic       vbus_present,
    output logic       orient,
    output logic       src_att_n,
    output logic       cur_med_n,
    output logic       cur_high_n,
    output logic       audio_n,
    output logic [1:0] cc_pull,
    output logic [1:0] vconn_en,
    output logic       chg_pulse
);
    localparam int DB_W = $clog2(imax(imax(DB_MS0, DB_MS1), imax(DB_MS2, DB_MS3)) + 1);
    localparam int VB_W = $clog2(VBUS_MS + 1);

    state_e     st_q, st_nx;
    logic [3:0] cc_q, cc_nx, cc_now;
    logic       orient_q, orient_nx;
    logic       src_cand, snk_cand, adv_src, src_phase;
    logic       db_done, db_clr, db_base_clr, vb_done;
    logic [DB_W-1:0] db_limit;
    pull_e      pull;

    assign cc_now = {cc2_cls, cc1_cls};

    // Classify the live CC pattern as a candidate for either role
    always_comb begin
        src_cand = ((cc1_cls == CLS_RD) ^ (cc2_cls == CLS_RD)) ||
                   ((cc1_cls == CLS_RA) && (cc2_cls == CLS_RA));
        snk_cand = (cc1_cls != CLS_OPEN) ^ (cc2_cls != CLS_OPEN);
        adv_src  = (mode_sel == MODE_SRC) || (mode_sel[1] && src_phase);
    end

    // Pick the debounce length
    always_comb begin
        case (db_sel)
            2'b00:   db_limit = DB_W'(DB_MS0);
            2'b01:   db_limit = DB_W'(DB_MS1);
            2'b10:   db_limit = DB_W'(DB_MS2);
            default: db_limit = DB_W'(DB_MS3);
        endcase
    end

    // Next-state and capture logic of the attach FSM
    always_comb begin
        st_nx     = st_q;
        cc_nx     = cc_q;
        orient_nx = orient_q;
        case (st_q)
            ST_DIS: st_nx = ST_UNATT;
            ST_UNATT: begin
                if (adv_src && src_cand) begin
                    st_nx = ST_WAIT_SRC;
                    cc_nx = cc_now;
                end else if (!adv_src && snk_cand) begin
                    st_nx = ST_WAIT_SNK;
                    cc_nx = cc_now;
                end
            end
            ST_WAIT_SRC: begin
                if (cc_now != cc_q) begin
                    if (src_cand) cc_nx = cc_now;
                    else          st_nx = ST_UNATT;
                end else if (db_done) begin
                    orient_nx = (cc2_cls == CLS_RD);
                    st_nx = ((cc1_cls == CLS_RA) && (cc2_cls == CLS_RA)) ?
                            ST_ATT_AUD : ST_ATT_SRC;
                end
            end
            ST_WAIT_SNK: begin
                if (cc_now != cc_q) begin
                    if (snk_cand) cc_nx = cc_now;
                    else          st_nx = ST_UNATT;
                end else if (db_done && vb_done) begin
                    orient_nx = (cc2_cls != CLS_OPEN);
                    st_nx     = ST_ATT_SNK;
                end
            end
            ST_ATT_SNK: if (!vbus_present) st_nx = ST_UNATT;
            ST_ATT_SRC, ST_ATT_AUD: if (db_done) st_nx = ST_UNATT;
            default: st_nx = ST_DIS;
        endcase
        if (en_n) st_nx = ST_DIS;
    end

    // Decide when the shared debounce timer must restart
    always_comb begin
        case (st_q)
            ST_WAIT_SRC, ST_WAIT_SNK: db_base_clr = (cc_now != cc_q);
            ST_ATT_SRC: db_base_clr = ((orient_q ? cc2_cls : cc1_cls) == CLS_RD);
            ST_ATT_AUD: db_base_clr = (cc1_cls == CLS_RA) && (cc2_cls == CLS_RA);
            default:    db_base_clr = 1'b1;
        endcase
        db_clr = db_base_clr || (st_nx != st_q);
    end

    // Termination select from state and dual-role phase
    always_comb begin
        case (st_q)
            ST_DIS:                              pull = PULL_NONE;
            ST_UNATT:                            pull = adv_src ? PULL_UP : PULL_DOWN;
            ST_WAIT_SRC, ST_ATT_SRC, ST_ATT_AUD: pull = PULL_UP;
            default:                             pull = PULL_DOWN;
        endcase
    end
    assign cc_pull = pull;

    // State, captured pattern and orientation registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= ST_DIS;
            cc_q     <= '0;
            orient_q <= 1'b0;
        end else begin
            st_q     <= st_nx;
            cc_q     <= (st_nx == ST_DIS) ? 4'h0 : cc_nx;
            orient_q <= (st_nx == ST_DIS) ? 1'b0 : orient_nx;
        end
    end

    cc_ms_timer #(.W(DB_W)) i_db_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (db_clr),
        .tick  (ms_tick),
        .limit (db_limit),
        .done  (db_done)
    );

    cc_ms_timer #(.W(VB_W)) i_vbus_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!vbus_present || (st_q == ST_DIS)),
        .tick  (ms_tick),
        .limit (VB_W'(VBUS_MS)),
        .done  (vb_done)
    );

    cc_drp_toggle #(.PERIOD_MS(PERIOD_MS)) i_drp (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (st_q == ST_DIS),
        .run       ((st_q == ST_UNATT) && mode_sel[1]),
        .tick      (ms_tick),
        .duty_sel  (duty_sel),
        .src_phase (src_phase)
    );

    cc_status_out i_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .st         (st_q),
        .orient_q   (orient_q),
        .cc_q       (cc_q),
        .cc_now     (cc_now),
        .orient     (orient),
        .src_att_n  (src_att_n),
        .cur_med_n  (cur_med_n),
        .cur_high_n (cur_high_n),
        .audio_n    (audio_n),
        .vconn_en   (vconn_en),
        .chg_pulse  (chg_pulse)
    );
endmodule

// File: rtl/cc_port_ctrl_chk.sv
// Checker for cc_port_ctrl: port-level temporal properties, bound to the top.
// Assumes the same clock and synchronous reset as the design.
module cc_port_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       en_n,
    input logic       vbus_present,
    input logic       orient,
    input logic       src_att_n,
    input logic       cur_med_n,
    input logic       cur_high_n,
    input logic       audio_n,
    input logic [1:0] cc_pull,
    input logic [1:0] vconn_en,
    input logic       chg_pulse
);
    // R1
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_n |=> (cc_pull == 2'b00 && vconn_en == 2'b00 && src_att_n && cur_med_n &&
                  cur_high_n && audio_n && !orient && !chg_pulse));
    // R7
    src_pullup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !src_att_n |-> cc_pull == 2'b10);
    // R8
    cur_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cur_high_n |-> !cur_med_n);
    // R9
    vconn_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vconn_en != 2'b00) |-> ($onehot0(vconn_en) && !src_att_n));
    // R5
    sink_vbus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cur_med_n |-> $past(vbus_present));
    // R6
    orient_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!src_att_n && $past(!src_att_n)) |-> $stable(orient));
    // R12
    attach_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(src_att_n) |-> chg_pulse);
    // R10
    audio_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !audio_n |-> (src_att_n && cur_med_n));
endmodule

bind cc_port_ctrl cc_port_ctrl_chk i_chk (.*);

// File: tb/test_cc_port_ctrl.sv
// Directed bench for cc_port_ctrl with a behavioural port partner.
module test_cc_port_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_n = 1'b1;
    logic [1:0] mode_sel = 2'b00, db_sel = 2'b00, duty_sel = 2'b00;
    logic       ms_tick = 1'b0;
    logic [1:0] cc1_cls, cc2_cls;
    logic       vbus_present = 1'b0;
    logic       orient, src_att_n, cur_med_n, cur_high_n, audio_n, chg_pulse;
    logic [1:0] cc_pull, vconn_en;

    int checks = 0, errors = 0, pulses = 0, tdiv = 0;
    int p_kind = 0;           // 0 none, 1 sink, 2 source, 3 cable, 4 audio
    int p_pin = 1;
    logic [1:0] p_lvl = 2'b01;
    bit finished = 0;

    always #10 clk = ~clk;    // 50 MHz

    cc_port_ctrl i_cc_port_ctrl (.*);

    // Tick every fourth cycle, counted away from the active edge
    always @(negedge clk) begin
        tdiv    <= (tdiv == 3) ? 0 : tdiv + 1;
        ms_tick <= (tdiv == 3);
        if (chg_pulse) pulses <= pulses + 1;
    end

    // Partner model: what the comparators report for the termination presented
    always_comb begin
        cc1_cls = 2'b00;
        cc2_cls = 2'b00;
        if (cc_pull == 2'b10) begin
            if (p_kind == 1 || p_kind == 3) begin
                if (p_pin == 1) cc1_cls = 2'b01; else cc2_cls = 2'b01;
            end
            if (p_kind == 3) begin
                if (p_pin == 1) cc2_cls = 2'b10; else cc1_cls = 2'b10;
            end
            if (p_kind == 4) begin
                cc1_cls = 2'b10;
                cc2_cls = 2'b10;
            end
        end else if (cc_pull == 2'b01 && p_kind == 2) begin
            if (p_pin == 1) cc1_cls = p_lvl; else cc2_cls = p_lvl;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_ms(input int n);
        repeat (n * 4) @(negedge clk);
    endtask

    task automatic t_reset;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 pull", cc_pull, 0);
        chk("R1 flags", {src_att_n, cur_med_n, cur_high_n, audio_n}, 4'b1111);
        chk("R1 vconn/orient", {vconn_en, orient}, 0);
    endtask

    task automatic t_sink_attach;
        int p0;
        mode_sel = 2'b00; db_sel = 2'b00; en_n = 1'b0;
        wait_ms(2);
        chk("R2 sink pulldown", cc_pull, 1);
        p0 = pulses;
        p_kind = 2; p_pin = 1; p_lvl = 2'b10; vbus_present = 1'b1;
        wait_ms(160);
        chk("R4 before debounce", cur_med_n, 1);
        wait_ms(12);
        chk("R8 medium", {cur_med_n, cur_high_n}, 2'b01);
        chk("R6 cc1 orient", orient, 0);
        chk("R12 attach pulse", pulses - p0, 1);
        p_lvl = 2'b11;
        wait_ms(1);
        chk("R8 high", {cur_med_n, cur_high_n}, 2'b00);
        vbus_present = 1'b0;
        repeat (2) @(negedge clk);
        chk("R5 vbus detach", {cur_med_n, cur_high_n}, 2'b11);
        p_kind = 0;
        wait_ms(2);
    endtask

    task automatic t_vbus_gate;
        p_kind = 2; p_pin = 2; p_lvl = 2'b01; vbus_present = 1'b0;
        wait_ms(180);
        chk("R5 no vbus no attach", orient, 0);
        vbus_present = 1'b1;
        @(negedge clk);
        chk("R5 vbus not yet debounced", orient, 0);
        wait_ms(4);
        chk("R6 cc2 orient", orient, 1);
        chk("R8 default", {cur_med_n, cur_high_n}, 2'b11);
        vbus_present = 1'b0;
        repeat (2) @(negedge clk);
        chk("R5 detach", orient, 0);
        p_kind = 0;
        wait_ms(2);
    endtask

    task automatic t_src_attach;
        mode_sel = 2'b01;
        wait_ms(2);
        chk("R2 source pullup", cc_pull, 2);
        p_kind = 1; p_pin = 2;
        wait_ms(174);
        chk("R7 source attached", src_att_n, 0);
        chk("R6 source orient", orient, 1);
        chk("R9 no vconn", vconn_en, 0);
        p_kind = 0;
        wait_ms(100);
        chk("R11 held during debounce", src_att_n, 0);
        wait_ms(80);
        chk("R11 detached", src_att_n, 1);
    endtask

    task automatic t_cable;
        p_kind = 3; p_pin = 1;
        wait_ms(175);
        chk("R9 vconn on cc2", vconn_en, 2);
        chk("R6 cable orient", orient, 0);
        p_kind = 0;
        wait_ms(175);
        chk("R9 vconn off", vconn_en, 0);
    endtask

    task automatic t_audio;
        p_kind = 4;
        wait_ms(175);
        chk("R10 audio", {audio_n, src_att_n}, 2'b01);
        p_kind = 0;
        wait_ms(175);
        chk("R10 audio removed", audio_n, 1);
    endtask

    task automatic t_restart;
        db_sel = 2'b11;
        p_kind = 1; p_pin = 1;
        wait_ms(60);
        p_pin = 2;
        wait_ms(60);
        chk("R4 restart on change", src_att_n, 1);
        wait_ms(45);
        chk("R4 attach after restart", {src_att_n, orient}, 2'b01);
        p_kind = 0;
        wait_ms(110);
        chk("R11 restart detach", src_att_n, 1);
    endtask

    task automatic measure_duty(input logic [1:0] d, input int exp_up);
        int up = 0, per = 0, guard = 0;
        logic [1:0] prev;
        duty_sel = d;
        prev = cc_pull;
        @(negedge clk);
        while (!(prev != 2'b10 && cc_pull == 2'b10) && guard < 2000) begin
            prev = cc_pull;
            @(negedge clk);
            guard++;
        end
        prev = cc_pull;
        do begin
            if (cc_pull == 2'b10) up++;
            per++;
            prev = cc_pull;
            @(negedge clk);
        end while (!(prev != 2'b10 && cc_pull == 2'b10) && per < 2000);
        chk("R3 period cycles", per, 300);
        chk("R3 source share", (up >= exp_up - 4 && up <= exp_up + 4) ? 1 : 0, 1);
    endtask

    task automatic t_drp;
        mode_sel = 2'b10; db_sel = 2'b00;
        measure_duty(2'b00, 88);
        measure_duty(2'b10, 148);
        duty_sel = 2'b00;
        p_kind = 2; p_pin = 1; p_lvl = 2'b11; vbus_present = 1'b1;
        wait_ms(260);
        chk("R3 dual-role resolved sink", {cc_pull, cur_high_n, src_att_n}, 4'b0101);
        vbus_present = 1'b0; p_kind = 0;
        wait_ms(2);
        measure_duty(2'b00, 88);
    endtask

    task automatic t_disable;
        int p0;
        mode_sel = 2'b01; db_sel = 2'b11;
        p_kind = 1; p_pin = 1;
        wait_ms(106);
        chk("R7 attached before disable", src_att_n, 0);
        p0 = pulses;
        en_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 disabled pull", cc_pull, 0);
        chk("R1 disabled flags", {src_att_n, audio_n}, 2'b11);
        wait_ms(2);
        chk("R1 no pulse while disabled", pulses - p0, 0);
        p_kind = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_sink_attach();
        t_vbus_gate();
        t_src_attach();
        t_cable();
        t_audio();
        t_restart();
        t_drp();
        t_disable();
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule